// File: doc/BRIEF.md
# Multicycle Stack-Capable Processor Core

This block is a small 32-bit processor core that runs 16-bit instructions through one shared memory port. Each instruction passes through a fetch step, a decode step that latches the source registers, an execute step, and for memory and stack operations one more step. The register file has sixteen 32-bit entries. Entry 15 is the program counter and entry 14 is the stack pointer, so both are visible to ordinary register operands. A three-bit status word (zero, negative, carry) is set by register add and subtract and is tested by conditional branches.

The core drives a byte address, write data and a write strobe, and it takes read data back on the same cycle. The attached memory is word-organised. It selects a word with address bits [31:2], returns that word within the cycle, and stores a word on the rising clock edge while the strobe is high. The `fetch` output is high in the cycle in which an instruction word is read, so the surrounding system can see where each instruction starts.

Top module: `cpu_core`

## Requirements
- R1: While `rst` is high (synchronous, active high), and in the first cycle after it falls, `fetch` is 1, `mem_we` is 0 and `mem_addr` equals RESET_PC. Reset loads RESET_PC into register 15, RESET_SP into register 14, zero into every other register and zero into the status word.
- R2: In a fetch cycle, `mem_addr` is register 15. The instruction is bits [15:0] of the returned word when register 15 bit 1 is 0, and bits [31:16] when it is 1. Register 15 then advances by 2. Fields: opcode [15:12], d [11:8], n [7:4], m [3:0].
- R3: Opcode 0010 writes Rn+Rm into Rd and opcode 0011 writes Rn-Rm into Rd. Both set Z when the result is zero and N to result bit 31. C is the carry out on add, and on subtract C is 1 when Rn >= Rm unsigned.
- R4: Opcode 1100 writes bits [7:0], zero-extended, into Rd.
- R5: Opcode 1000 loads Rd from, and opcode 1001 stores Rd to, byte address Rn + m*4, where m is bits [3:0] as an unsigned value.
- R6: Opcode 1101 tests condition bits [11:10] (00 Z set, 01 N clear, 10 N set, 11 C set). When the condition holds, register 15 (already advanced by 2) becomes itself + offset*2 + 2, where the offset is bits [9:0] as a signed value. Otherwise execution goes on with the next instruction.
- R7: Opcode 1111 with n field 0 (push) stores Rd at the address in register 14, then lowers register 14 by 4.
- R8: Opcode 1111 with n field 1 (pop) raises register 14 by 4, then loads Rd from the address in register 14.
- R9: Opcode 1111 with n field 2 (call) pushes register 15 as R7 describes, then sets register 15 to the value Rd had before the instruction.
- R10: Opcode 1111 with n field 3 (return) pops the word at register 14 + 4 into register 15 and raises register 14 by 4.
- R11: From one fetch to the next takes 3 cycles for add, subtract, immediate load, branch, push and no-op instructions, and 4 cycles for memory load, memory store, pop, call and return.
- R12: Every other opcode, and opcode 1111 with n field 4 to 15, changes nothing except the advance of register 15 and makes no memory write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address to memory |
| mem_wdata | output | 32 | Word to be written |
| mem_we | output | 1 | Write strobe, word written at the next rising edge |
| mem_rdata | input | 32 | Word read at `mem_addr`, valid in the same cycle |
| fetch | output | 1 | High in each instruction fetch cycle |

## Verification
A directed prologue first checks the cases that random code rarely reaches. These are a subtract giving zero followed by a taken equal branch, a not-taken less-than branch, a subtract giving a negative result followed by a taken less-than branch, an add that carries out followed by a carry branch, and a push, pop, call and return round trip, with fetches from both halves of a word. After that, a stream of instructions drawn at random runs in lockstep with an instruction-level model in the bench. The stream has register fields, immediates and branch offsets drawn at random, and it is weighted toward arithmetic and stack operations, with unknown opcodes and unknown sub-operations mixed in. The bench compares every fetch address, which exposes wrong branch targets or return addresses. It compares every memory write for address and data, which exposes register, flag and stack pointer errors once the affected values are stored. It also compares the cycle count between fetches, which separates the 3-step instructions from the 4-step ones.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 16;
    localparam int RAW  = $clog2(NREG);

    localparam logic [RAW-1:0] SP_IDX = RAW'(14);
    localparam logic [RAW-1:0] PC_IDX = RAW'(15);

    localparam logic [3:0] OP_ADD3 = 4'h2;
    localparam logic [3:0] OP_SUB3 = 4'h3;
    localparam logic [3:0] OP_LDM  = 4'h8;
    localparam logic [3:0] OP_STM  = 4'h9;
    localparam logic [3:0] OP_LDI  = 4'hC;
    localparam logic [3:0] OP_BR   = 4'hD;
    localparam logic [3:0] OP_MISC = 4'hF;

    localparam logic [3:0] SUB_PUSH = 4'h0;
    localparam logic [3:0] SUB_POP  = 4'h1;
    localparam logic [3:0] SUB_CALL = 4'h2;
    localparam logic [3:0] SUB_RTS  = 4'h3;

    typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB} state_e;

    typedef enum logic [3:0] {
        K_NOP, K_ALU, K_LDI, K_LDM, K_STM, K_BR, K_PUSH, K_POP, K_CALL, K_RTS
    } kind_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
    } psw_t;

    function automatic kind_e classify(logic [15:0] w);
        kind_e k;
        k = K_NOP;
        case (w[15:12])
            OP_ADD3, OP_SUB3: k = K_ALU;
            OP_LDI:           k = K_LDI;
            OP_LDM:           k = K_LDM;
            OP_STM:           k = K_STM;
            OP_BR:            k = K_BR;
            OP_MISC: begin
                case (w[7:4])
                    SUB_PUSH: k = K_PUSH;
                    SUB_POP:  k = K_POP;
                    SUB_CALL: k = K_CALL;
                    SUB_RTS:  k = K_RTS;
                    default:  k = K_NOP;
                endcase
            end
            default: k = K_NOP;
        endcase
        return k;
    endfunction

    function automatic logic cond_met(logic [1:0] cc, psw_t p);
        logic r;
        case (cc)
            2'd0:    r = p.z;
            2'd1:    r = !p.n;
            2'd2:    r = p.n;
            default: r = p.c;
        endcase
        return r;
    endfunction

    function automatic logic four_step(kind_e k);
        return (k == K_LDM) || (k == K_STM) || (k == K_POP) ||
               (k == K_CALL) || (k == K_RTS);
    endfunction

    function automatic logic [XLEN-1:0] branch_target(logic [XLEN-1:0] pc, logic [9:0] off);
        return pc + {{(XLEN-11){off[9]}}, off, 1'b0} + XLEN'(2);
    endfunction
endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import cpu_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0,
    parameter logic [XLEN-1:0] RESET_SP = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RAW-1:0]  raddr_a,
    input  logic [RAW-1:0]  raddr_b,
    input  logic [RAW-1:0]  raddr_c,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b,
    output logic [XLEN-1:0] rdata_c,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] sp
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                if (RAW'(i) == PC_IDX)      regs[i] <= RESET_PC;
                else if (RAW'(i) == SP_IDX) regs[i] <= RESET_SP;
                else                        regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
    assign rdata_c = regs[raddr_c];
    assign pc      = regs[PC_IDX];
    assign sp      = regs[SP_IDX];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    output logic [XLEN-1:0] y,
    output psw_t            flags
);
    logic [XLEN:0] sum;

    always_comb begin
        sum     = {1'b0, a} + {1'b0, (sub ? ~b : b)} + {{XLEN{1'b0}}, sub};
        y       = sum[XLEN-1:0];
        flags.z = (sum[XLEN-1:0] == '0);
        flags.n = sum[XLEN-1];
        flags.c = sum[XLEN];
    end
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            pc_half,
    output state_e          state,
    output logic [15:0]     ir,
    output kind_e           kind
);
    assign kind = classify(ir);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_FETCH;
            ir    <= '0;
        end else begin
            case (state)
                S_FETCH: begin
                    ir    <= pc_half ? mem_rdata[31:16] : mem_rdata[15:0];
                    state <= S_DECODE;
                end
                S_DECODE: state <= S_EXEC;
                S_EXEC: begin
                    if (four_step(kind)) state <= (kind == K_CALL) ? S_WB : S_MEM;
                    else                 state <= S_FETCH;
                end
                default: state <= S_FETCH;
            endcase
        end
    end

    // R11: a fetch is always followed by decode
    p_fetch_then_decode_r11: assert property (@(posedge clk) disable iff (rst)
        state == S_FETCH |=> state == S_DECODE);

    // R9: only a call reaches the extra register write step
    p_wb_only_call_r9: assert property (@(posedge clk) disable iff (rst)
        state == S_WB |-> kind == K_CALL);

    // R2: the instruction register changes only on a fetch
    p_ir_held_r2: assert property (@(posedge clk) disable iff (rst)
        state != S_FETCH |=> $stable(ir));
endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] RESET_SP = 32'h0000_03FC
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        mem_we,
    input  logic [31:0] mem_rdata,
    output logic        fetch
);
    state_e          state;
    kind_e           kind;
    logic [15:0]     ir;
    logic [XLEN-1:0] rd_a, rd_b, rd_c, pc, sp;
    logic [XLEN-1:0] opa, opb, opc, mar;
    psw_t            psw, alu_flags;
    logic [XLEN-1:0] alu_y;
    logic            rf_we;
    logic [RAW-1:0]  rf_waddr, rb_addr;
    logic [XLEN-1:0] rf_wdata;

    cpu_ctrl u_ctrl (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .pc_half(pc[1]),
        .state(state), .ir(ir), .kind(kind)
    );

    // stack operations read the stack pointer through port B
    assign rb_addr = (ir[15:12] == OP_MISC) ? SP_IDX : ir[7:4];

    cpu_regfile #(.RESET_PC(RESET_PC), .RESET_SP(RESET_SP)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
        .raddr_a(ir[11:8]), .raddr_b(rb_addr), .raddr_c(ir[3:0]),
        .rdata_a(rd_a), .rdata_b(rd_b), .rdata_c(rd_c), .pc(pc), .sp(sp)
    );

    cpu_alu u_alu (
        .a(opb), .b(opc), .sub(ir[15:12] == OP_SUB3), .y(alu_y), .flags(alu_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opa <= '0;
            opb <= '0;
            opc <= '0;
            mar <= '0;
            psw <= '0;
        end else begin
            if (state == S_DECODE) begin
                opa <= rd_a;
                opb <= rd_b;
                opc <= rd_c;
            end
            if (state == S_EXEC) begin
                if (kind == K_LDM || kind == K_STM)
                    mar <= opb + {{(XLEN-6){1'b0}}, ir[3:0], 2'b00};
                else
                    mar <= opb + XLEN'(4);
                if (kind == K_ALU) psw <= alu_flags;
            end
        end
    end

    // single register write port, steered by step and instruction kind
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = ir[11:8];
        rf_wdata = alu_y;
        case (state)
            S_FETCH: begin
                rf_we    = 1'b1;
                rf_waddr = PC_IDX;
                rf_wdata = pc + XLEN'(2);
            end
            S_EXEC: begin
                case (kind)
                    K_ALU: rf_we = 1'b1;
                    K_LDI: begin
                        rf_we    = 1'b1;
                        rf_wdata = {{(XLEN-8){1'b0}}, ir[7:0]};
                    end
                    K_BR: begin
                        rf_we    = cond_met(ir[11:10], psw);
                        rf_waddr = PC_IDX;
                        rf_wdata = branch_target(pc, ir[9:0]);
                    end
                    K_PUSH, K_CALL: begin
                        rf_we    = 1'b1;
                        rf_waddr = SP_IDX;
                        rf_wdata = opb - XLEN'(4);
                    end
                    K_POP, K_RTS: begin
                        rf_we    = 1'b1;
                        rf_waddr = SP_IDX;
                        rf_wdata = opb + XLEN'(4);
                    end
                    default: rf_we = 1'b0;
                endcase
            end
            S_MEM: begin
                rf_we    = (kind == K_LDM) || (kind == K_POP) || (kind == K_RTS);
                rf_waddr = (kind == K_RTS) ? PC_IDX : ir[11:8];
                rf_wdata = mem_rdata;
            end
            S_WB: begin
                rf_we    = 1'b1;
                rf_waddr = PC_IDX;
                rf_wdata = opa;
            end
            default: rf_we = 1'b0;
        endcase
    end

    // shared memory port
    always_comb begin
        mem_addr  = pc;
        mem_wdata = opa;
        mem_we    = 1'b0;
        if (state == S_EXEC && (kind == K_PUSH || kind == K_CALL)) begin
            mem_addr  = opb;
            mem_we    = 1'b1;
            mem_wdata = (kind == K_CALL) ? pc : opa;
        end else if (state == S_MEM) begin
            mem_addr = mar;
            mem_we   = (kind == K_STM);
        end
    end

    assign fetch = (state == S_FETCH);

    // R2: every fetch advances the program counter by one halfword
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        state == S_FETCH |=> pc == $past(pc) + 32'd2);

    // R7: a push lowers the stack pointer by one word
    p_push_sp_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && kind == K_PUSH) |=> sp == $past(sp) - 32'd4);

    // R8: a pop raises the stack pointer by one word
    p_pop_sp_r8: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && kind == K_POP) |=> sp == $past(sp) + 32'd4);

    // R5: memory writes happen only in execute or memory steps
    p_write_step_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (state == S_EXEC || state == S_MEM));

    // R3: status word changes only in an execute step
    p_psw_hold_r3: assert property (@(posedge clk) disable iff (rst)
        state != S_EXEC |=> $stable(psw));

    // R9: call lands on the latched target register value
    p_call_target_r9: assert property (@(posedge clk) disable iff (rst)
        state == S_WB |=> pc == $past(opa));
endmodule

// File: tb/sim_cpu_core.sv
module sim_cpu_core;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int          MW      = 256;
    localparam int          NINS    = 4000;
    localparam logic [31:0] R_PC    = 32'h0000_0000;
    localparam logic [31:0] R_SP    = 32'h0000_03FC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, fetch;

    always #2.5 clk = ~clk;

    logic [31:0] dm [MW];
    assign mem_rdata = dm[mem_addr[9:2]];
    always @(posedge clk) if (mem_we) dm[mem_addr[9:2]] <= mem_wdata;

    cpu_core #(.RESET_PC(R_PC), .RESET_SP(R_SP)) u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .fetch(fetch)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // instruction-level model
    logic [31:0] mm [MW];
    logic [31:0] mr [16];
    logic        fz, fn, fc;
    logic        exp_st;
    logic [31:0] exp_sa, exp_sd;
    int          exp_cyc;
    string       itag, ftag, nftag;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(int op, int d, int n, int m);
        return {op[3:0], d[3:0], n[3:0], m[3:0]};
    endfunction

    task automatic put_h(int addr, logic [15:0] h);
        logic [31:0] w;
        w = dm[addr[9:2]];
        if (addr[1]) w[31:16] = h; else w[15:0] = h;
        dm[addr[9:2]] = w;
        mm[addr[9:2]] = w;
    endtask

    function automatic logic [15:0] rand_insn();
        int sel;
        sel = $urandom_range(0, 15);
        case (sel)
            0, 1, 14, 15: return enc(2, $urandom_range(0, 13), $urandom_range(0, 15), $urandom_range(0, 15));
            2:  return enc(3, $urandom_range(0, 13), $urandom_range(0, 15), $urandom_range(0, 15));
            3, 4: return {4'hC, 4'($urandom_range(0, 13)), 8'($urandom)};
            5:  return enc(8, $urandom_range(0, 13), $urandom_range(0, 15), $urandom_range(0, 15));
            6:  return enc(9, $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15));
            7:  return {4'hD, 12'($urandom)};
            8:  return enc(15, $urandom_range(0, 15), 0, $urandom_range(0, 15));
            9:  return enc(15, $urandom_range(0, 15), 1, $urandom_range(0, 15));
            10: return enc(15, $urandom_range(0, 15), 2, $urandom_range(0, 15));
            11: return enc(15, $urandom_range(0, 15), 3, $urandom_range(0, 15));
            12: return enc(15, $urandom_range(0, 15), $urandom_range(4, 15), $urandom_range(0, 15));
            default: begin
                case ($urandom_range(0, 8))
                    0: return {4'h0, 12'($urandom)};
                    1: return {4'h1, 12'($urandom)};
                    2: return {4'h4, 12'($urandom)};
                    3: return {4'h5, 12'($urandom)};
                    4: return {4'h6, 12'($urandom)};
                    5: return {4'h7, 12'($urandom)};
                    6: return {4'hA, 12'($urandom)};
                    7: return {4'hB, 12'($urandom)};
                    default: return {4'hE, 12'($urandom)};
                endcase
            end
        endcase
    endfunction

    task automatic do_store(logic [31:0] a, logic [31:0] d);
        exp_st = 1'b1;
        exp_sa = a;
        exp_sd = d;
        mm[a[9:2]] = d;
    endtask

    task automatic model_step();
        logic [31:0] word, a, b, t;
        logic [32:0] s;
        logic [15:0] w;
        logic [3:0]  op, d, n, m;
        bit          take;
        word = mm[mr[15][9:2]];
        w = mr[15][1] ? word[31:16] : word[15:0];
        mr[15] = mr[15] + 32'd2;
        op = w[15:12]; d = w[11:8]; n = w[7:4]; m = w[3:0];
        exp_st = 1'b0; exp_cyc = 3; itag = "R12"; nftag = "R2";
        case (op)
            4'h2: begin
                a = mr[n]; b = mr[m];
                s = {1'b0, a} + {1'b0, b};
                mr[d] = s[31:0];
                fz = (s[31:0] == 0); fn = s[31]; fc = s[32];
                itag = "R3";
            end
            4'h3: begin
                a = mr[n]; b = mr[m];
                t = a - b;
                mr[d] = t;
                fz = (t == 0); fn = t[31]; fc = (a >= b);
                itag = "R3";
            end
            4'hC: begin mr[d] = {24'd0, w[7:0]}; itag = "R4"; end
            4'h8: begin
                a = mr[n] + 32'(m) * 4;
                mr[d] = mm[a[9:2]];
                exp_cyc = 4; itag = "R5";
            end
            4'h9: begin
                a = mr[n] + 32'(m) * 4;
                do_store(a, mr[d]);
                exp_cyc = 4; itag = "R5";
            end
            4'hD: begin
                case (w[11:10])
                    2'd0: take = fz;
                    2'd1: take = !fn;
                    2'd2: take = fn;
                    default: take = fc;
                endcase
                t = {{22{w[9]}}, w[9:0]};
                if (take) mr[15] = mr[15] + (t << 1) + 32'd2;
                itag = "R6"; nftag = "R6";
            end
            4'hF: begin
                case (n)
                    4'd0: begin
                        do_store(mr[14], mr[d]);
                        mr[14] = mr[14] - 32'd4;
                        itag = "R7";
                    end
                    4'd1: begin
                        mr[14] = mr[14] + 32'd4;
                        mr[d] = mm[mr[14][9:2]];
                        exp_cyc = 4; itag = "R8";
                    end
                    4'd2: begin
                        t = mr[d];
                        do_store(mr[14], mr[15]);
                        mr[14] = mr[14] - 32'd4;
                        mr[15] = t;
                        exp_cyc = 4; itag = "R9"; nftag = "R9";
                    end
                    4'd3: begin
                        mr[14] = mr[14] + 32'd4;
                        mr[15] = mm[mr[14][9:2]];
                        exp_cyc = 4; itag = "R10"; nftag = "R10";
                    end
                    default: itag = "R12";
                endcase
            end
            default: itag = "R12";
        endcase
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int  cyc, seen;
        bit  hung;
        void'($urandom(32'd2024));
        for (int i = 0; i < MW; i++) begin
            dm[i] = '0;
            mm[i] = '0;
        end
        for (int i = 0; i < 16; i++) mr[i] = '0;
        mr[15] = R_PC; mr[14] = R_SP;
        fz = 0; fn = 0; fc = 0;

        // random body, then the directed prologue on top of it
        for (int a = 46; a < 4 * MW; a += 2) put_h(a, rand_insn());
        put_h(0,  16'hC105);   // LDI r1,5
        put_h(2,  16'hC205);   // LDI r2,5
        put_h(4,  16'h3312);   // SUB r3=r1-r2 -> zero
        put_h(6,  16'hD001);   // branch on zero, taken to 12
        put_h(8,  16'hC401);
        put_h(10, 16'hC402);
        put_h(12, 16'hD805);   // branch on negative, not taken
        put_h(14, 16'hF100);   // push r1
        put_h(16, 16'hF510);   // pop r5
        put_h(18, 16'hC628);   // LDI r6,40
        put_h(20, 16'hF620);   // call r6
        put_h(22, 16'h9561);   // store r5 at r6+4
        put_h(24, 16'hC7FF);   // LDI r7,255
        put_h(26, 16'h3807);   // SUB r8=r0-r7 -> negative
        put_h(28, 16'hD800);   // branch on negative, taken to 32
        put_h(30, 16'h4000);
        put_h(32, 16'hC901);   // LDI r9,1
        put_h(34, 16'h3A09);   // SUB r10=0-1
        put_h(36, 16'h2BAA);   // ADD r11=r10+r10 -> carry
        put_h(38, 16'hDC02);   // branch on carry, taken to 46
        put_h(40, 16'hF030);   // return
        put_h(42, 16'h4000);
        put_h(44, 16'h4000);

        repeat (3) @(negedge clk);
        chk(fetch == 1'b1, "R1 fetch", 32'(fetch), 32'd1);
        chk(mem_we == 1'b0, "R1 write", 32'(mem_we), 32'd0);
        chk(mem_addr == R_PC, "R1 addr", mem_addr, R_PC);
        rst = 1'b0;

        hung = 0;
        ftag = "R1";
        for (int k = 0; k < NINS && !hung; k++) begin
            chk(fetch === 1'b1 && mem_addr == mr[15], ftag, mem_addr, mr[15]);
            model_step();
            cyc = 0;
            seen = 0;
            do begin
                @(negedge clk);
                cyc++;
                if (mem_we) begin
                    seen++;
                    chk(exp_st && mem_addr == exp_sa, {itag, " store addr"}, mem_addr, exp_sa);
                    chk(exp_st && mem_wdata == exp_sd, {itag, " store data"}, mem_wdata, exp_sd);
                end
            end while (!fetch && cyc < 16);
            if (!fetch) begin
                hung = 1;
                chk(1'b0, "R11 watchdog", 32'(cyc), 32'(exp_cyc));
            end else begin
                chk(cyc == exp_cyc, {"R11 ", itag}, 32'(cyc), 32'(exp_cyc));
                if (exp_st) chk(seen == 1, {itag, " store count"}, 32'(seen), 32'd1);
            end
            ftag = nftag;
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule